// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block holds the two offset values that a FIFO's programmable flag logic compares against: the empty-side offset and the full-side offset. When master reset is active, the block samples a load-mode pin and a two-bit select input. From these it fixes the programming mode for the whole session, either bit-serial or parallel word. It also loads one of eight preset values into both offsets.

After reset the offsets can be rewritten at any time. A low load-control input steers the write and read strobes away from the FIFO and onto the offset registers. In parallel mode a write takes a whole word from the data input. In serial mode a write shifts in one bit per clock. Readback always uses the parallel output bus and alternates between the two offsets. Any value above the FIFO's last valid position is clamped to it. When the load-control input is high, the strobes and read data pass through to the FIFO core, and the offsets stay as they are.

Top module: `fofs_prog`

## Requirements
- R1: The load mode is captured from `cfg_serial` on every clock with `rst_n` low: 1 selects serial, 0 selects parallel. After reset the mode does not follow the pin until the next reset.
- R2: On every clock with `rst_n` low, both offsets take the preset value 1023 >> idx, where idx = {cfg_serial, cfg_sel[1], cfg_sel[0]} (3 bits, cfg_serial as MSB). This gives 1023, 511, 255, 127, 63, 31, 15 and 7 for idx 0 to 7.
- R3: In parallel mode, each clock with `ofs_ld_n` low and `wr_en` high writes `wdata` to one offset. The first write after reset goes to the empty offset and the next to the full offset, alternating from then on. The new value is visible on the outputs after that edge.
- R4: In serial mode, each clock with `ofs_ld_n` low and `wr_en` high shifts in `ser_in`, least significant bit first, and `wdata` is ignored. After OFS_W bits the assembled word goes to the empty offset. The next OFS_W bits go to the full offset, and then loading returns to the empty offset. An offset keeps its old value until its last bit arrives.
- R5: A clock with `ofs_ld_n` low and `rd_en` high presents one offset on `rdata`, zero-extended, after that edge. Reads take the empty offset first and then the full offset, alternating, in either mode. The value stays on `rdata` until the next read.
- R6: A value above DEPTH-1, whether from the parallel or the serial path, is stored as DEPTH-1.
- R7: With `ofs_ld_n` high, `fifo_we` equals `wr_en`, `fifo_re` equals `rd_en`, and after a FIFO read `rdata` follows `fifo_rdata`. With `ofs_ld_n` low, or `rst_n` low, both FIFO strobes are 0.
- R8: The offsets change only on reset or on an offset write (with `ofs_ld_n` low and `wr_en` high). Reads and FIFO traffic leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, sampled synchronously |
| cfg_serial | input | 1 | Load-mode pin sampled during reset (1 = serial) |
| cfg_sel | input | 2 | Preset select sampled during reset |
| ofs_ld_n | input | 1 | Low: strobes address the offsets; high: strobes go to the FIFO |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| ser_in | input | 1 | Serial offset bit |
| wdata | input | DATA_W | Parallel write data |
| fifo_rdata | input | DATA_W | Read data from the FIFO core |
| fifo_we | output | 1 | Write strobe to the FIFO core |
| fifo_re | output | 1 | Read strobe to the FIFO core |
| rdata | output | DATA_W | Read data bus (offset or FIFO word) |
| empty_ofs | output | OFS_W | Empty-side offset to the flag logic |
| full_ofs | output | OFS_W | Full-side offset to the flag logic |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any check that relies on the captured mode or presets. They also assume that, after reset, the configuration pins may change freely without effect. The stimulus always begins with a reset pulse of two clocks. It moves the configuration pins away from their reset values once reset is released, and it changes every input only on the falling clock edge. This keeps the strobes stable around each rising edge.

// File: rtl/fofs_pkg.sv
package fofs_pkg;
   typedef enum logic {TGT_EMPTY = 1'b0, TGT_FULL = 1'b1} ofs_tgt_e;
   typedef enum logic {LOAD_PAR = 1'b0, LOAD_SER = 1'b1} load_mode_e;

   localparam int unsigned PRESET_TOP = 1023;
   localparam int unsigned PRESET_W   = 10;

   // preset ladder: top value halved (rounded down) per index step
   function automatic logic [PRESET_W-1:0] preset_value(input logic [2:0] idx);
      return PRESET_W'(PRESET_TOP >> idx);
   endfunction
endpackage

// File: rtl/fofs_defaults.sv
module fofs_defaults #(
   parameter int OUT_W = 11
) (
   input  logic [2:0]       idx,
   output logic [OUT_W-1:0] val
);
   import fofs_pkg::*;

   if (OUT_W < PRESET_W) begin : g_bad_w
      initial $fatal(1, "fofs_defaults: OUT_W too small for presets");
   end

   assign val = OUT_W'(preset_value(idx));
endmodule

// File: rtl/fofs_clamp.sv
module fofs_clamp #(
   parameter int     IN_W  = 16,
   parameter int     OUT_W = 11,
   parameter longint LIMIT = 1999
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam longint IN_MAX = (longint'(1) << IN_W) - 1;
   localparam int     CW     = (IN_W > OUT_W) ? IN_W : OUT_W;

   if (LIMIT >= IN_MAX) begin : g_pass
      // input range cannot exceed the limit: no comparator needed
      assign dout = OUT_W'(din);
   end else begin : g_cmp
      logic [CW-1:0] ext;
      assign ext  = CW'(din);
      assign dout = (ext > CW'(LIMIT)) ? OUT_W'(LIMIT) : OUT_W'(din);
   end
endmodule

// File: rtl/fofs_shift.sv
module fofs_shift #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic         done,
   output logic [W-1:0] word
);
   localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   logic [W-1:0]     sh_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (shift_en) begin
         sh_q  <= {bit_in, sh_q[W-1:1]};
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   // the word completes on the edge that takes in its final bit
   assign done = shift_en && (cnt_q == LAST);
   assign word = {bit_in, sh_q[W-1:1]};
endmodule

// File: rtl/fofs_steer.sv
module fofs_steer #(
   parameter int DATA_W = 16,
   parameter int OFS_W  = 11
) (
   input  logic              rst_n,
   input  logic              ofs_ld_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              show_ofs,
   input  logic [OFS_W-1:0]  ofs_word,
   input  logic [DATA_W-1:0] fifo_rdata,
   output logic              fifo_we,
   output logic              fifo_re,
   output logic [DATA_W-1:0] rdata
);
   assign fifo_we = rst_n & ofs_ld_n & wr_en;
   assign fifo_re = rst_n & ofs_ld_n & rd_en;
   assign rdata   = show_ofs ? DATA_W'(ofs_word) : fifo_rdata;
endmodule

// File: rtl/fofs_prog.sv
module fofs_prog #(
   parameter int DEPTH  = 2000,
   parameter int DATA_W = 16,
   localparam int OFS_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_serial,
   input  logic [1:0]        cfg_sel,
   input  logic              ofs_ld_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              ser_in,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] fifo_rdata,
   output logic              fifo_we,
   output logic              fifo_re,
   output logic [DATA_W-1:0] rdata,
   output logic [OFS_W-1:0]  empty_ofs,
   output logic [OFS_W-1:0]  full_ofs
);
   import fofs_pkg::*;

   localparam longint LIMIT = longint'(DEPTH) - 1;

   if (DEPTH < 1024) begin : g_bad_depth
      initial $fatal(1, "fofs_prog: DEPTH must be at least 1024");
   end
   if (DATA_W < OFS_W) begin : g_bad_data
      initial $fatal(1, "fofs_prog: DATA_W narrower than offset");
   end

   load_mode_e       mode_q;
   ofs_tgt_e         wptr_q, rptr_q;
   logic [OFS_W-1:0] n_q, m_q, hold_q;
   logic             show_q;

   logic [OFS_W-1:0] preset, par_val, ser_raw, ser_val, new_val;
   logic             ofs_wr, ofs_rd, fifo_rd, ser_done, commit;

   assign ofs_wr  = rst_n & ~ofs_ld_n & wr_en;
   assign ofs_rd  = rst_n & ~ofs_ld_n & rd_en;
   assign fifo_rd = rst_n &  ofs_ld_n & rd_en;

   fofs_defaults #(.OUT_W(OFS_W)) u_def (
      .idx ({cfg_serial, cfg_sel}),
      .val (preset)
   );

   fofs_clamp #(.IN_W(DATA_W), .OUT_W(OFS_W), .LIMIT(LIMIT)) u_pclamp (
      .din  (wdata),
      .dout (par_val)
   );

   fofs_shift #(.W(OFS_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (ofs_wr && (mode_q == LOAD_SER)),
      .bit_in   (ser_in),
      .done     (ser_done),
      .word     (ser_raw)
   );

   fofs_clamp #(.IN_W(OFS_W), .OUT_W(OFS_W), .LIMIT(LIMIT)) u_sclamp (
      .din  (ser_raw),
      .dout (ser_val)
   );

   always_comb begin
      if (mode_q == LOAD_SER) begin
         commit  = ser_done;
         new_val = ser_val;
      end else begin
         commit  = ofs_wr;
         new_val = par_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= load_mode_e'(cfg_serial);
         n_q    <= preset;
         m_q    <= preset;
         wptr_q <= TGT_EMPTY;
      end else if (commit) begin
         if (wptr_q == TGT_EMPTY) n_q <= new_val;
         else                     m_q <= new_val;
         wptr_q <= (wptr_q == TGT_EMPTY) ? TGT_FULL : TGT_EMPTY;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rptr_q <= TGT_EMPTY;
         hold_q <= '0;
         show_q <= 1'b0;
      end else if (ofs_rd) begin
         hold_q <= (rptr_q == TGT_EMPTY) ? n_q : m_q;
         show_q <= 1'b1;
         rptr_q <= (rptr_q == TGT_EMPTY) ? TGT_FULL : TGT_EMPTY;
      end else if (fifo_rd) begin
         show_q <= 1'b0;
      end
   end

   fofs_steer #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_steer (
      .rst_n      (rst_n),
      .ofs_ld_n   (ofs_ld_n),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .show_ofs   (show_q),
      .ofs_word   (hold_q),
      .fifo_rdata (fifo_rdata),
      .fifo_we    (fifo_we),
      .fifo_re    (fifo_re),
      .rdata      (rdata)
   );

   assign empty_ofs = n_q;
   assign full_ofs  = m_q;
endmodule

// File: rtl/fofs_prog_chk.sv
module fofs_prog_chk #(
   parameter int DEPTH  = 2000,
   parameter int DATA_W = 16,
   localparam int OFS_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_serial,
   input logic [1:0]       cfg_sel,
   input logic             ofs_ld_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic             fifo_we,
   input logic             fifo_re,
   input logic [OFS_W-1:0] empty_ofs,
   input logic [OFS_W-1:0] full_ofs,
   input logic             mode_q
);
   logic             rst_q;
   logic [OFS_W-1:0] def_q;

   always_ff @(posedge clk) begin
      rst_q <= rst_n;
      if (!rst_n) def_q <= OFS_W'(10'd1023 >> {cfg_serial, cfg_sel});
   end

   p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> $stable(mode_q));

   p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_q |-> (empty_ofs == def_q && full_ofs == def_q));

   p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (longint'(empty_ofs) < longint'(DEPTH)) && (longint'(full_ofs) < longint'(DEPTH)));

   p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_ld_n |-> (fifo_we == wr_en && fifo_re == rd_en));

   p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ofs_ld_n |-> (!fifo_we && !fifo_re));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_q && !(!ofs_ld_n && wr_en)) |=> ($stable(empty_ofs) && $stable(full_ofs)));
endmodule

bind fofs_prog fofs_prog_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_serial (cfg_serial),
   .cfg_sel    (cfg_sel),
   .ofs_ld_n   (ofs_ld_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .fifo_we    (fifo_we),
   .fifo_re    (fifo_re),
   .empty_ofs  (empty_ofs),
   .full_ofs   (full_ofs),
   .mode_q     (mode_q)
);

// File: tb/fofs_prog_tb.sv
module fofs_prog_tb;
   localparam int DEPTH  = 2000;
   localparam int DATA_W = 16;
   localparam int OFS_W  = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_serial = 1'b0;
   logic [1:0]        cfg_sel = 2'd0;
   logic              ofs_ld_n = 1'b1;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic              ser_in = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] fifo_rdata = '0;
   logic              fifo_we, fifo_re;
   logic [DATA_W-1:0] rdata;
   logic [OFS_W-1:0]  empty_ofs, full_ofs;

   int errors = 0;
   int checks = 0;
   int exp_q[$];
   logic done = 1'b0;

   always #4 clk = ~clk;

   fofs_prog #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
      .clk, .rst_n, .cfg_serial, .cfg_sel, .ofs_ld_n, .wr_en, .rd_en,
      .ser_in, .wdata, .fifo_rdata, .fifo_we, .fifo_re, .rdata,
      .empty_ofs, .full_ofs
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int clampv(input int v);
      return (v > DEPTH - 1) ? DEPTH - 1 : v;
   endfunction

   // scoreboard monitor: offset reads are compared one edge later
   always @(posedge clk) begin
      logic issued;
      issued = rst_n && !ofs_ld_n && rd_en;
      #2;
      if (issued) begin
         if (exp_q.size() == 0) check("R5 unexpected read", 1, 0);
         else check("R5 readback", int'(rdata), exp_q.pop_front());
      end
   end

   task automatic do_reset(input logic ser, input logic [1:0] sel);
      @(negedge clk);
      rst_n = 1'b0; cfg_serial = ser; cfg_sel = sel; wr_en = 1'b1; ofs_ld_n = 1'b1;
      @(negedge clk);
      check("R7 strobe blocked in reset", int'(fifo_we), 0);
      wr_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      cfg_serial = ~ser; cfg_sel = ~sel;   // pins move after reset
      check("R2 preset empty", int'(empty_ofs), 1023 >> {ser, sel});
      check("R2 preset full", int'(full_ofs), 1023 >> {ser, sel});
   endtask

   task automatic pwrite(input int val);
      @(negedge clk);
      ofs_ld_n = 1'b0; wr_en = 1'b1; wdata = DATA_W'(val);
      #1 check("R7 fifo_we low on offset write", int'(fifo_we), 0);
      @(negedge clk);
      ofs_ld_n = 1'b1; wr_en = 1'b0;
   endtask

   task automatic swrite(input int val, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         ofs_ld_n = 1'b0; wr_en = 1'b1; ser_in = val[i]; wdata = '1;
      end
      @(negedge clk);
      ofs_ld_n = 1'b1; wr_en = 1'b0;
   endtask

   task automatic oread(input int exp);
      @(negedge clk);
      exp_q.push_back(exp);
      ofs_ld_n = 1'b0; rd_en = 1'b1;
      @(negedge clk);
      ofs_ld_n = 1'b1; rd_en = 1'b0;
   endtask

   initial begin
      // parallel session, preset index 2
      do_reset(1'b0, 2'd2);
      pwrite(100);
      check("R3 first write to empty", int'(empty_ofs), 100);
      check("R3 full untouched", int'(full_ofs), 255);
      pwrite(200);
      check("R3 second write to full", int'(full_ofs), 200);
      pwrite(3000);
      check("R6 parallel clamp", int'(empty_ofs), clampv(3000));
      pwrite(5);
      check("R3 alternation", int'(full_ofs), 5);
      oread(DEPTH - 1);
      oread(5);
      repeat (3) @(negedge clk);
      check("R5 readback held", int'(rdata), 5);
      check("R8 reads keep empty", int'(empty_ofs), DEPTH - 1);
      // FIFO pass-through
      @(negedge clk);
      fifo_rdata = 16'hBEEF; wr_en = 1'b1; rd_en = 1'b1; ofs_ld_n = 1'b1;
      #1;
      check("R7 fifo_we passthrough", int'(fifo_we), 1);
      check("R7 fifo_re passthrough", int'(fifo_re), 1);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R7 rdata follows fifo", int'(rdata), 16'hBEEF);
      check("R8 fifo traffic keeps full", int'(full_ofs), 5);

      // serial session, preset index 7
      do_reset(1'b1, 2'd3);
      swrite(12'h155, OFS_W - 1);
      check("R4 empty held until last bit", int'(empty_ofs), 7);
      swrite(0, 1);
      check("R4 serial empty LSB first", int'(empty_ofs), 12'h155 & ((1 << OFS_W) - 1));
      check("R1 serial mode kept, wdata ignored", int'(full_ofs), 7);
      swrite(2047, OFS_W);
      check("R6 serial clamp", int'(full_ofs), clampv(2047));
      swrite(9, OFS_W);
      check("R4 pointer back to empty", int'(empty_ofs), 9);
      oread(9);
      oread(DEPTH - 1);
      oread(9);

      // more presets, parallel
      do_reset(1'b0, 2'd0);
      do_reset(1'b1, 2'd0);
      do_reset(1'b0, 2'd1);
      pwrite(0);
      check("R3 zero offset", int'(empty_ofs), 0);
      oread(0);
      oread(511);
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule